// File: doc/BRIEF.md
# Peripheral Register Bus Router

This block sits between a processor's control-register port and ten peripheral register banks. Each 32-bit access arrives on a valid/ready request port. Physical address bits [28:16], taken after the top three address bits are cleared, select the bank. Bits [7:2] pick one of 64 word slots inside that bank. A per-slot access policy then decides the outcome. The slot may refuse the access, read back as a constant zero, keep the word in local storage, or send the access out to the owning peripheral on a strobe/acknowledge port.

Each bank checks the access against its own upper address limit, and the write limit can be lower than the read limit. An access past the limit, or to a region that no bank claims, completes at once and raises the error flag. Two write-only regions accept writes and read as zero without error. Two queue-address-control words sit at fixed full addresses and capture writes directly, ahead of the normal decode. Software loads the policy table through a configuration port after reset.

Top module: `reg_router`

## Requirements
- R1: After reset, every slot is no-access, both queue-address-control outputs are zero, the misalignment warning is clear, and every read returns 0.
- R2: Bank index 0..9 is chosen by masked address bits [28:16] equal to 0x1F00, 0x1F20, 0x1F80, 0x1FA0, 0x1FC0, 0x1FC8, 0x1FD0, 0x1FD8, 0x1FE0 and 0x1FE8, in that order. The slot is address bits [7:2].
- R3: A read whose masked address exceeds its bank's read limit returns 0 and sets rsp_err. The limits are 0x1F000044, 0x1F200020, 0x1F800048, 0x1FA00040, 0x1FC00010, 0x1FC8003C, 0x1FD00010, 0x1FD8002C, 0x1FE0001C and 0x1FE80024 for banks 0..9.
- R4: A write above its bank's write limit is dropped and sets rsp_err. The write limits equal the read limits, except bank 0, whose write limit is 0x1F00003C.
- R5: cfg_we loads cfg_pol into slot (cfg_bank, cfg_slot). In cfg_pol, bits [1:0] are the mode: 0 = no access, 1 = constant, 2 = active, and 3 = no access. Bit 2 forwards reads and bit 3 forwards writes, and both apply only in active mode.
- R6: A no-access slot returns 0 on reads, ignores writes and does not set rsp_err.
- R7: A constant slot reads as 0 and ignores writes.
- R8: An active slot without write forwarding stores the write word. An active slot without read forwarding returns the stored word.
- R9: A forwarded access drives per_valid with the bank, slot, direction and write data, and holds req_ready low until per_ack. A forwarded read returns per_rdata.
- R10: Every access that is not forwarded completes in the cycle it is presented (req_ready high).
- R11: Masked regions 0x1F90 and 0x1F94 read as 0 and accept writes, with rsp_err low.
- R12: An access to any other unclaimed region reads 0, has no effect and sets rsp_err.
- R13: A write to full address 0xFF000038 or 0xFF00003C loads qac0_o or qac1_o respectively and does not reach the slot storage. Reads of those addresses and aliases with other top bits decode normally.
- R14: A nonzero addr[1:0] is treated as the aligned word and sets warn_o, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Policy table write strobe |
| cfg_bank | input | 4 | Bank index for policy write |
| cfg_slot | input | 6 | Slot index for policy write |
| cfg_pol | input | 4 | Policy word ({wfwd, rfwd, mode[1:0]}) |
| req_valid | input | 1 | Access request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Access completes this cycle |
| rsp_rdata | output | 32 | Read data, valid with req_valid and req_ready (0 for writes) |
| rsp_err | output | 1 | Range/region error, valid with the handshake |
| warn_o | output | 1 | Sticky misalignment warning |
| qac0_o | output | 32 | Queue-address-control word 0 |
| qac1_o | output | 32 | Queue-address-control word 1 |
| per_valid | output | 1 | Forwarded access strobe |
| per_write | output | 1 | Forwarded direction |
| per_bank | output | 4 | Forwarded bank index |
| per_slot | output | 6 | Forwarded slot index |
| per_wdata | output | 32 | Forwarded write data |
| per_ack | input | 1 | Peripheral acknowledge |
| per_rdata | input | 32 | Peripheral read data |

## Verification
The hardest case is the gap between bank 0's write limit and its read limit. The slot at offset 0x40 must reject a write with an error but still accept a read, and the read must show the word unchanged. The stimulus first makes that slot locally stored, then writes to it and reads it back. The queue-address-control aliases are reached in a similar way. A write through the full address must leave the slot behind it empty, while a write through an alias with different top bits must land in that slot and leave the queue word alone.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int ADDR_W = 32;
  localparam int NBANK  = 10;
  localparam int BANK_W = $clog2(NBANK);
  localparam int CODE_W = 13;

  localparam logic [ADDR_W-1:0] QAC0_ADDR = 32'hFF00_0038;
  localparam logic [ADDR_W-1:0] QAC1_ADDR = 32'hFF00_003C;
  localparam logic [CODE_W-1:0] WO_CODE_A = 13'h1F90;
  localparam logic [CODE_W-1:0] WO_CODE_B = 13'h1F94;

  typedef enum logic [1:0] {
    POL_NONE   = 2'd0,
    POL_CONST  = 2'd1,
    POL_ACTIVE = 2'd2,
    POL_RSVD   = 2'd3
  } mode_t;

  typedef struct packed {
    logic  wfwd;
    logic  rfwd;
    mode_t mode;
  } pol_t;

  function automatic logic [CODE_W-1:0] bank_code(input int unsigned b);
    case (b)
      0: bank_code = 13'h1F00;
      1: bank_code = 13'h1F20;
      2: bank_code = 13'h1F80;
      3: bank_code = 13'h1FA0;
      4: bank_code = 13'h1FC0;
      5: bank_code = 13'h1FC8;
      6: bank_code = 13'h1FD0;
      7: bank_code = 13'h1FD8;
      8: bank_code = 13'h1FE0;
      9: bank_code = 13'h1FE8;
      default: bank_code = '1;
    endcase
  endfunction

  // Highest legal byte offset for reads inside each bank
  function automatic logic [7:0] rd_limit(input int unsigned b);
    case (b)
      0: rd_limit = 8'h44;
      1: rd_limit = 8'h20;
      2: rd_limit = 8'h48;
      3: rd_limit = 8'h40;
      4: rd_limit = 8'h10;
      5: rd_limit = 8'h3C;
      6: rd_limit = 8'h10;
      7: rd_limit = 8'h2C;
      8: rd_limit = 8'h1C;
      9: rd_limit = 8'h24;
      default: rd_limit = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wr_limit(input int unsigned b);
    wr_limit = (b == 0) ? 8'h3C : rd_limit(b);
  endfunction
endpackage

// File: rtl/rr_decode.sv
module rr_decode
  import rr_pkg::*;
#(
  parameter int SLOT_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [BANK_W-1:0] bank,
  output logic [SLOT_W-1:0] slot,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic              wo_hit,
  output logic              unaligned
);
  logic [28:0]       m;
  logic [NBANK-1:0]  match;
  logic [7:0]        rl, wl;

  assign m = addr[28:0];

  for (genvar g = 0; g < NBANK; g++) begin : g_match
    assign match[g] = (m[28:16] == bank_code(g));
  end

  always_comb begin
    bank = '0;
    rl   = '0;
    wl   = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (match[b]) begin
        bank = BANK_W'(b);
        rl   = rd_limit(b);
        wl   = wr_limit(b);
      end
    end
  end

  assign hit       = |match;
  assign rd_ok     = hit && (m[15:8] == 8'h00) && (m[7:0] <= rl);
  assign wr_ok     = hit && (m[15:8] == 8'h00) && (m[7:0] <= wl);
  assign wo_hit    = (m[28:16] == WO_CODE_A) || (m[28:16] == WO_CODE_B);
  assign slot      = addr[SLOT_W+1:2];
  assign unaligned = |addr[1:0];
endmodule

// File: rtl/rr_policy_table.sv
module rr_policy_table
  import rr_pkg::*;
#(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  pol_t              cfg_pol,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [SLOT_W-1:0] rd_slot,
  output pol_t              rd_pol
);
  localparam int SLOTS = 1 << SLOT_W;

  pol_t tbl [NBANK][SLOTS];
  logic wr_en;

  assign wr_en = cfg_we && (cfg_bank < BANK_W'(NBANK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++)
        for (int s = 0; s < SLOTS; s++)
          tbl[b][s] <= '0;
    end else if (wr_en) begin
      tbl[cfg_bank][cfg_slot] <= cfg_pol;
    end
  end

  assign rd_pol = (rd_bank < BANK_W'(NBANK)) ? tbl[rd_bank][rd_slot] : '0;
endmodule

// File: rtl/rr_word_store.sv
module rr_word_store
  import rr_pkg::*;
#(
  parameter int SLOT_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BANK_W-1:0] bank,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [DATA_W-1:0] mem [NBANK][SLOTS];
  logic              in_map;

  assign in_map = bank < BANK_W'(NBANK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++)
        for (int s = 0; s < SLOTS; s++)
          mem[b][s] <= '0;
    end else if (we && in_map) begin
      mem[bank][slot] <= wdata;
    end
  end

  assign rdata = in_map ? mem[bank][slot] : '0;
endmodule

// File: rtl/reg_router.sv
module reg_router
  import rr_pkg::*;
#(
  parameter int SLOT_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [3:0]        cfg_pol,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              warn_o,
  output logic [DATA_W-1:0] qac0_o,
  output logic [DATA_W-1:0] qac1_o,
  output logic              per_valid,
  output logic              per_write,
  output logic [BANK_W-1:0] per_bank,
  output logic [SLOT_W-1:0] per_slot,
  output logic [DATA_W-1:0] per_wdata,
  input  logic              per_ack,
  input  logic [DATA_W-1:0] per_rdata
);
  logic              hit, rd_ok, wr_ok, wo_hit, unaligned;
  logic [BANK_W-1:0] bank;
  logic [SLOT_W-1:0] slot;
  pol_t              pol;
  logic [DATA_W-1:0] store_rdata;
  logic              is_qac0, is_qac1, in_range, active, act_mode;
  logic              fwd_rd, fwd_wr, loc_we, done;
  logic              warn_q, warn_d;
  logic [DATA_W-1:0] qac0_q, qac0_d, qac1_q, qac1_d;

  rr_decode #(.SLOT_W(SLOT_W)) u_dec (
    .addr(req_addr), .hit(hit), .bank(bank), .slot(slot),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .wo_hit(wo_hit), .unaligned(unaligned)
  );

  rr_policy_table #(.SLOT_W(SLOT_W)) u_pol (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_slot(cfg_slot), .cfg_pol(pol_t'(cfg_pol)),
    .rd_bank(bank), .rd_slot(slot), .rd_pol(pol)
  );

  rr_word_store #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(loc_we), .bank(bank), .slot(slot),
    .wdata(req_wdata), .rdata(store_rdata)
  );

  // Access classification
  always_comb begin
    is_qac0  = req_write && (req_addr == QAC0_ADDR);
    is_qac1  = req_write && (req_addr == QAC1_ADDR);
    in_range = req_write ? wr_ok : rd_ok;
    active   = hit && in_range && !is_qac0 && !is_qac1;
    act_mode = (pol.mode == POL_ACTIVE);
    fwd_rd   = active && !req_write && act_mode && pol.rfwd;
    fwd_wr   = active &&  req_write && act_mode && pol.wfwd;
    per_valid = req_valid && (fwd_rd || fwd_wr);
    req_ready = per_valid ? per_ack : 1'b1;
    done      = req_valid && req_ready;
    loc_we    = req_valid && active && req_write && act_mode && !pol.wfwd;
    if (req_write)                 rsp_rdata = '0;
    else if (fwd_rd)               rsp_rdata = per_rdata;
    else if (active && act_mode)   rsp_rdata = store_rdata;
    else                           rsp_rdata = '0;
    rsp_err = !is_qac0 && !is_qac1 && !wo_hit && !(hit && in_range);
  end

  assign per_write = req_write;
  assign per_bank  = bank;
  assign per_slot  = slot;
  assign per_wdata = req_wdata;

  // Next state for sticky warning and queue-address-control words
  always_comb begin
    warn_d = warn_q | (done && unaligned);
    qac0_d = (done && is_qac0) ? req_wdata : qac0_q;
    qac1_d = (done && is_qac1) ? req_wdata : qac1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      qac0_q <= '0;
      qac1_q <= '0;
    end else begin
      warn_q <= warn_d;
      qac0_q <= qac0_d;
      qac1_q <= qac1_d;
    end
  end

  assign warn_o = warn_q;
  assign qac0_o = qac0_q;
  assign qac1_o = qac1_q;

  // R9
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_valid && !per_ack) |-> !req_ready);

  // R10
  local_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !per_valid) |-> req_ready);

  // R14
  warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn_o |=> warn_o);

  // R13
  qac0_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(qac0_o) |-> $past(req_valid && req_ready && req_write && (req_addr == QAC0_ADDR)));

  // R3
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && rsp_err) |-> (rsp_rdata == '0 && !per_valid));
endmodule

// File: tb/tb_reg_router.sv
module tb_reg_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_bank = '0;
  logic [5:0]  cfg_slot = '0;
  logic [3:0]  cfg_pol = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_err, warn_o, per_valid, per_write;
  logic [31:0] rsp_rdata, qac0_o, qac1_o, per_wdata;
  logic [3:0]  per_bank;
  logic [5:0]  per_slot;
  logic        per_ack = 1'b0;
  logic [31:0] per_rdata = '0;

  int total = 0, bad = 0;
  int fwd_count = 0, wait_cnt = 0;
  logic        last_w;
  logic [31:0] last_wdata;
  logic [3:0]  last_bank;
  logic [5:0]  last_slot;

  typedef struct {
    logic [31:0] rdata;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  reg_router dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Peripheral model: acknowledges after a short delay
  always @(negedge clk) begin
    #1;
    if (per_ack) per_ack = 1'b0;
    else if (per_valid) begin
      if (wait_cnt == 2) begin
        per_ack    = 1'b1;
        per_rdata  = 32'hA500_0000 | {20'h0, per_bank, 2'b00, per_slot};
        last_w     = per_write;
        last_wdata = per_wdata;
        last_bank  = per_bank;
        last_slot  = per_slot;
        fwd_count++;
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  // Monitor: pops expected items as accesses complete
  always @(negedge clk) begin
    #2;
    if (req_valid && req_ready) begin
      if (sb.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " rdata"}, rsp_rdata, e.rdata);
        chk({e.tag, " err"}, {31'd0, rsp_err}, {31'd0, e.err});
      end
    end
  end

  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] wd,
                        input logic [31:0] exp, input logic exp_err,
                        input logic exp_fwd, input string tag);
    int waits;
    exp_t e;
    e.rdata = exp; e.err = exp_err; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd;
    waits = 0;
    forever begin
      #3;
      if (req_ready) break;
      waits++;
      @(negedge clk);
    end
    chk({tag, " wait"}, {31'd0, waits > 0}, {31'd0, exp_fwd});
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg(input int b, input int s, input logic [3:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 4'(b); cfg_slot = 6'(s); cfg_pol = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk("R1 warn", {31'd0, warn_o}, 32'd0);
    chk("R1 qac0", qac0_o, 32'd0);
    chk("R1 qac1", qac1_o, 32'd0);
    access(1'b0, 32'hFF00_0004, 0, 32'd0, 1'b0, 1'b0, "R1 read after reset");

    // R5 load policies
    cfg(0, 1, 4'b0010);   // local
    cfg(0, 2, 4'b0001);   // constant
    cfg(0, 14, 4'b0010);
    cfg(0, 16, 4'b0010);
    cfg(3, 5, 4'b1110);   // forward both ways
    cfg(7, 3, 4'b0110);   // forward reads only
    cfg(9, 0, 4'b0010);

    // R8 local store
    access(1'b1, 32'hFF00_0004, 32'hDEAD_BEEF, 0, 1'b0, 1'b0, "R8 write");
    access(1'b0, 32'hFF00_0004, 0, 32'hDEAD_BEEF, 1'b0, 1'b0, "R8 R10 read");
    // R7 constant
    access(1'b1, 32'hFF00_0008, 32'h1234, 0, 1'b0, 1'b0, "R7 write");
    access(1'b0, 32'hFF00_0008, 0, 0, 1'b0, 1'b0, "R7 read");
    // R6 no access
    access(1'b1, 32'hFF00_000C, 32'h55, 0, 1'b0, 1'b0, "R6 write");
    access(1'b0, 32'hFF00_000C, 0, 0, 1'b0, 1'b0, "R6 read");
    // R4 bank 0 write limit below read limit
    access(1'b1, 32'hFF00_0040, 32'h77, 0, 1'b1, 1'b0, "R4 write past limit");
    access(1'b0, 32'hFF00_0040, 0, 0, 1'b0, 1'b0, "R4 read in range unchanged");
    access(1'b1, 32'hFF00_0044, 32'h1, 0, 1'b1, 1'b0, "R4 write at read limit");
    // R3 read limit
    access(1'b0, 32'hFF00_0048, 0, 0, 1'b1, 1'b0, "R3 read past limit");
    access(1'b0, 32'hFFE8_0028, 0, 0, 1'b1, 1'b0, "R3 bank9 past limit");
    // R2 decode of last bank, alias through top bits
    access(1'b1, 32'h1FE8_0000, 32'h9999, 0, 1'b0, 1'b0, "R2 bank9 write");
    access(1'b0, 32'hFFE8_0000, 0, 32'h9999, 1'b0, 1'b0, "R2 bank9 read");

    // R9 forwarded accesses
    access(1'b0, 32'hFFA0_0014, 0, 32'hA500_0305, 1'b0, 1'b1, "R9 fwd read");
    access(1'b1, 32'hFFA0_0014, 32'hCAFE, 0, 1'b0, 1'b1, "R9 fwd write");
    chk("R9 per_write", {31'd0, last_w}, 32'd1);
    chk("R9 per_wdata", last_wdata, 32'hCAFE);
    chk("R9 per_bank", {28'd0, last_bank}, 32'd3);
    chk("R9 per_slot", {26'd0, last_slot}, 32'd5);
    n = fwd_count;
    access(1'b1, 32'hFFD8_000C, 32'hBEE, 0, 1'b0, 1'b0, "R8 local write on read-fwd slot");
    chk("R8 write not forwarded", 32'(fwd_count), 32'(n));
    access(1'b0, 32'hFFD8_000C, 0, 32'hA500_0703, 1'b0, 1'b1, "R9 read-fwd slot");

    // R11 write-only regions
    access(1'b0, 32'hFF90_0000, 0, 0, 1'b0, 1'b0, "R11 read");
    access(1'b1, 32'hFF94_0010, 32'h3, 0, 1'b0, 1'b0, "R11 write");
    // R12 unmapped
    access(1'b1, 32'hFF10_0000, 32'h3, 0, 1'b1, 1'b0, "R12 write");
    access(1'b0, 32'hFF10_0000, 0, 0, 1'b1, 1'b0, "R12 read");

    // R13 queue-address-control
    access(1'b1, 32'hFF00_0038, 32'h1C, 0, 1'b0, 1'b0, "R13 qac0 write");
    access(1'b1, 32'hFF00_003C, 32'h08, 0, 1'b0, 1'b0, "R13 qac1 write");
    chk("R13 qac0", qac0_o, 32'h1C);
    chk("R13 qac1", qac1_o, 32'h08);
    access(1'b0, 32'hFF00_0038, 0, 0, 1'b0, 1'b0, "R13 slot untouched");
    access(1'b1, 32'h1F00_0038, 32'h4242, 0, 1'b0, 1'b0, "R13 alias write");
    chk("R13 qac0 kept", qac0_o, 32'h1C);
    access(1'b0, 32'hFF00_0038, 0, 32'h4242, 1'b0, 1'b0, "R13 alias stored");

    // R14 misaligned
    chk("R14 warn before", {31'd0, warn_o}, 32'd0);
    access(1'b0, 32'hFF00_0006, 0, 32'hDEAD_BEEF, 1'b0, 1'b0, "R14 unaligned read");
    chk("R14 warn set", {31'd0, warn_o}, 32'd1);
    access(1'b0, 32'hFF00_0004, 0, 32'hDEAD_BEEF, 1'b0, 1'b0, "R14 aligned read");
    chk("R14 warn sticky", {31'd0, warn_o}, 32'd1);

    // R5 reload a policy
    cfg(0, 1, 4'b0000);
    access(1'b0, 32'hFF00_0004, 0, 0, 1'b0, 1'b0, "R5 reloaded to none");
    cfg(0, 1, 4'b0011);
    access(1'b0, 32'hFF00_0004, 0, 0, 1'b0, 1'b0, "R5 mode 3 is none");

    repeat (2) @(negedge clk);
    chk("scoreboard drained", 32'(sb.size()), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule